// File: doc/BRIEF.md
# Suspend Wake Source Monitor

This block sits beside a USB device core and watches for reasons to end a bus suspend. While the device is suspended it watches three sources: an active-low external wake pin, a rising edge on the PHY link status and a one-cycle pulse from a magic-packet detector outside this block. It turns a qualifying event into a one-cycle wake request strobe, which the resume logic elsewhere acts on.

The host sets the behaviour through an 8-bit monitor register, written and read over a plain byte interface. Three low bits are stored: a master monitor enable, a link-up wake enable and a magic-packet wake enable. The upper read-back bits carry a fixed pattern and the current bus speed. A remote-wakeup support flag word loaded from EEPROM must also allow wakeup, or no request is ever raised. After a request the block stays silent until suspend is released. It rearms from then on.

Top module: `wake_monitor_top`

## Requirements
- R1: While reset is held and right after it, the stored enables are 0, `wakeReq` is 0 and `regRdData` reads 8'hA0 with bit 4 equal to `hsMode`.
- R2: `regRdData` always shows 3'b101 in bits 7:5, `hsMode` in bit 4 (1 = high speed, 0 = full speed), 0 in bit 3 and the stored enables in bits 2:0. Bit 0 is the monitor enable, bit 1 is the link-up enable and bit 2 is the magic-packet enable.
- R3: A cycle with `regWrEn` high stores `regWrData[2:0]`, visible from the next cycle. `regWrData[7:3]` has no effect on any read-back bit.
- R4: `extWakeN` passes through a two-flop synchronizer. It is a wake event only after the synchronized level has been low on three consecutive clock edges. If the pin is first sampled low at edge 1 and stays low, `wakeReq` is high after edge 5. A low lasting two samples raises nothing.
- R5: A 0-to-1 change of `linkUp` is a wake event when enable bit 1 is set, and `wakeReq` is high after the edge that samples the new level. A link that was already up when suspend began raises nothing. A rise with bit 1 clear raises nothing.
- R6: A `magicPulse` with enable bit 2 set gives `wakeReq` after the same edge. With bit 2 clear it gives nothing.
- R7: No request is raised unless `suspendIn` is high and enable bit 0 is set in the cycle of the event.
- R8: No request is raised unless bit 2 of `eeFlags` (remote-wakeup support) is set.
- R9: `wakeReq` lasts exactly one cycle and rises at most once per suspend period. The block rearms once `suspendIn` is low.
- R10: When a register write and a wake event fall in the same cycle, that cycle's decision uses the enables stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extWakeN | input | 1 | External wake pin, active low, asynchronous |
| linkUp | input | 1 | PHY link status, 1 = link up |
| magicPulse | input | 1 | One-cycle magic-packet detect pulse |
| suspendIn | input | 1 | USB device is suspended |
| hsMode | input | 1 | 1 = high-speed operation, 0 = full speed |
| eeFlags | input | 16 | EEPROM flag word; bit 2 permits remote wakeup |
| regWrEn | input | 1 | Write strobe for the monitor register |
| regWrData | input | 8 | Write data for the monitor register |
| regRdData | output | 8 | Monitor register read-back |
| wakeReq | output | 1 | One-cycle remote wakeup request |

## Verification
A host write to the monitor register can fall in the same clock cycle as a wake event. The main case is a write that clears the link enable while the link rises. The bench drives the write strobe and the link edge from the same falling edge, so both are sampled at one rising edge. It then expects a request on the next cycle, because the old enables govern that cycle, and expects the cleared value on read-back. A second case lets a suspend release and a magic pulse meet. That case must give no request.

// File: rtl/wake_pkg.sv
package wake_pkg;

  // Qualified, enable-gated wake sources seen by the control
  typedef struct packed {
    logic extHit;
    logic linkHit;
    logic magicHit;
    logic monEn;
  } srcEvents_t;

  // Strobes from the control back to the datapath
  typedef struct packed {
    logic wakeFire;
  } ctrlStrobe_t;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_SPENT = 1'b1
  } armState_t;

endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 3,
  parameter int REG_W       = 8,
  parameter int EN_BITS     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extWakeN,
  input  logic             linkUp,
  input  logic             magicPulse,
  input  logic             hsMode,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  ctrlStrobe_t      ctrl,
  output srcEvents_t       srcEvt,
  output logic [REG_W-1:0] regRdData,
  output logic             wakeReq
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_LOW - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_LOW);
  localparam int PAD_W = REG_W - EN_BITS - 5;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   extSync;
  logic [CNT_W-1:0]       lowCnt;
  logic                   linkPrev;
  logic [EN_BITS-1:0]     monReg;
  logic                   unusedWrBits;

  // Synchronizer chain for the asynchronous wake pin (idles high)
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= extWakeN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], extWakeN};
      end
    end
  endgenerate

  assign extSync = syncChain[SYNC_STAGES-1];

  // Consecutive-low counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (extSync)       lowCnt <= '0;
    else if (lowCnt != CNT_SAT) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkPrev <= 1'b0;
    else       linkPrev <= linkUp;
  end

  // Monitor register: only the enable field is stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        monReg <= '0;
    else if (regWrEn) monReg <= regWrData[EN_BITS-1:0];
  end

  assign unusedWrBits = ^regWrData[REG_W-1:EN_BITS];

  always_comb begin
    srcEvt.extHit   = !extSync && (lowCnt == CNT_LAST);
    srcEvt.linkHit  = linkUp && !linkPrev && monReg[1];
    srcEvt.magicHit = magicPulse && monReg[2];
    srcEvt.monEn    = monReg[0];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign regRdData = {3'b101, hsMode, {PAD_W{1'b0}}, 1'b0, monReg};
    end else begin : g_nopad
      assign regRdData = {3'b101, hsMode, 1'b0, monReg};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeReq <= 1'b0;
    else       wakeReq <= ctrl.wakeFire;
  end

endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        suspendIn,
  input  logic        supportOk,
  input  srcEvents_t  srcEvt,
  output ctrlStrobe_t ctrl
);

  armState_t state;
  logic      anyHit;

  assign anyHit = srcEvt.extHit || srcEvt.linkHit || srcEvt.magicHit;

  always_comb begin
    ctrl.wakeFire = (state == ST_ARMED) && suspendIn && supportOk &&
                    srcEvt.monEn && anyHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              state <= ST_ARMED;
    else if (!suspendIn)    state <= ST_ARMED;
    else if (ctrl.wakeFire) state <= ST_SPENT;
  end

endmodule

// File: rtl/wake_monitor_top.sv
module wake_monitor_top
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 3,
  parameter int FLAG_W      = 16,
  parameter int RW_BIT      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extWakeN,
  input  logic              linkUp,
  input  logic              magicPulse,
  input  logic              suspendIn,
  input  logic              hsMode,
  input  logic [FLAG_W-1:0] eeFlags,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              wakeReq
);

  srcEvents_t  srcEvt;
  ctrlStrobe_t ctrl;
  logic        supportOk;
  logic        unusedFlags;

  assign supportOk   = eeFlags[RW_BIT];
  assign unusedFlags = ^eeFlags;

  wake_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_LOW),
    .REG_W      (8),
    .EN_BITS    (3)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extWakeN  (extWakeN),
    .linkUp    (linkUp),
    .magicPulse(magicPulse),
    .hsMode    (hsMode),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .ctrl      (ctrl),
    .srcEvt    (srcEvt),
    .regRdData (regRdData),
    .wakeReq   (wakeReq)
  );

  wake_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .suspendIn(suspendIn),
    .supportOk(supportOk),
    .srcEvt   (srcEvt),
    .ctrl     (ctrl)
  );

endmodule

// File: rtl/wake_monitor_chk.sv
module wake_monitor_chk #(
  parameter int FLAG_W = 16,
  parameter int RW_BIT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              extWakeN,
  input logic              linkUp,
  input logic              magicPulse,
  input logic              suspendIn,
  input logic              hsMode,
  input logic [FLAG_W-1:0] eeFlags,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic              wakeReq
);

  logic spentSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          spentSeen <= 1'b0;
    else if (!suspendIn) spentSeen <= 1'b0;
    else if (wakeReq)   spentSeen <= 1'b1;
  end

  // R2: fixed pattern and speed bit on read-back
  a_r2_read_format: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7:5] == 3'b101) && (regRdData[4] == hsMode) && !regRdData[3]);

  // R3: a write lands in the stored enables on the next cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[2:0] == $past(regWrData[2:0])));

  // R7: a request follows a suspended cycle with monitor mode on
  a_r7_needs_monitor: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(suspendIn && regRdData[0]));

  // R8: a request requires the EEPROM support flag
  a_r8_needs_support: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(eeFlags[RW_BIT]));

  // R9: single-cycle strobe
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);

  // R9: at most one request per suspend period
  a_r9_once_per_suspend: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> !spentSeen);

endmodule

bind wake_monitor_top wake_monitor_chk #(.FLAG_W(FLAG_W), .RW_BIT(RW_BIT)) u_chk (.*);

// File: tb/tb_wake_monitor_top.sv
module tb_wake_monitor_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extWakeN = 1'b1;
  logic        linkUp = 1'b0;
  logic        magicPulse = 1'b0;
  logic        suspendIn = 1'b0;
  logic        hsMode = 1'b1;
  logic [15:0] eeFlags = 16'h0004;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        wakeReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wake_monitor_top dut (
    .clk(clk), .rstN(rstN), .extWakeN(extWakeN), .linkUp(linkUp),
    .magicPulse(magicPulse), .suspendIn(suspendIn), .hsMode(hsMode),
    .eeFlags(eeFlags), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .wakeReq(wakeReq)
  );

  // {write data[16:9], hsMode[8], expected read-back[7:0]}
  localparam logic [16:0] VEC [0:5] = '{
    {8'hFF, 1'b1, 8'hB7},
    {8'h00, 1'b0, 8'hA0},
    {8'h05, 1'b1, 8'hB5},
    {8'hF8, 1'b0, 8'hA0},
    {8'h02, 1'b0, 8'hA2},
    {8'h0B, 1'b1, 8'hB3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setReg(input logic [7:0] v);
    regWrEn = 1'b1;
    regWrData = v;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rearm();
    suspendIn = 1'b0;
    tick();
    suspendIn = 1'b1;
    tick();
  endtask

  task automatic countPulses(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (wakeReq) c++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    // R1: reset state
    tick();
    chk("R1 reset read-back", regRdData, 8'hB0);
    chk("R1 reset wakeReq", wakeReq, 0);
    rstN = 1'b1;
    tick();
    chk("R1 after reset read-back", regRdData, 8'hB0);

    // R2, R3: register vectors (not suspended, so no wake)
    for (int i = 0; i < 6; i++) begin
      hsMode = VEC[i][8];
      setReg(VEC[i][16:9]);
      chk($sformatf("R2 R3 vector %0d", i), regRdData, VEC[i][7:0]);
    end
    hsMode = 1'b0;

    // R4: exact latency of a held low on the pin
    setReg(8'h01);
    rearm();
    extWakeN = 1'b0;
    repeat (4) tick();
    chk("R4 no request before fifth edge", wakeReq, 0);
    tick();
    chk("R4 request after fifth edge", wakeReq, 1);
    tick();
    chk("R9 request lasts one cycle", wakeReq, 0);
    countPulses(8, c);
    chk("R9 held pin gives no second request", c, 0);
    extWakeN = 1'b1;
    repeat (4) tick();

    // R4: two-sample glitch ignored, three-sample low accepted
    rearm();
    extWakeN = 1'b0;
    repeat (2) tick();
    extWakeN = 1'b1;
    countPulses(10, c);
    chk("R4 two-sample low ignored", c, 0);
    extWakeN = 1'b0;
    repeat (3) tick();
    extWakeN = 1'b1;
    countPulses(10, c);
    chk("R4 three-sample low accepted", c, 1);

    // R5: link rise with and without enable
    setReg(8'h01);
    rearm();
    linkUp = 1'b1;
    countPulses(4, c);
    chk("R5 link rise with bit1 clear", c, 0);
    linkUp = 1'b0;
    setReg(8'h03);
    rearm();
    linkUp = 1'b1;
    tick();
    chk("R5 link rise latency", wakeReq, 1);
    tick();
    chk("R9 link request one cycle", wakeReq, 0);

    // R5: link already up when suspend begins
    rearm();
    countPulses(6, c);
    chk("R5 link already up gives nothing", c, 0);
    linkUp = 1'b0;
    tick();

    // R6: magic pulse with and without enable
    setReg(8'h03);
    rearm();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    countPulses(3, c);
    chk("R6 magic with bit2 clear", c, 0);
    setReg(8'h05);
    rearm();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    chk("R6 magic latency", wakeReq, 1);

    // R9: second magic in the same suspend, then rearm
    tick();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    countPulses(3, c);
    chk("R9 second event same suspend", c, 0);
    rearm();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    chk("R9 request after rearm", wakeReq, 1);

    // R7: monitor bit clear, and not suspended
    setReg(8'h06);
    rearm();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    countPulses(3, c);
    chk("R7 monitor bit clear", c, 0);
    setReg(8'h07);
    suspendIn = 1'b0;
    tick();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    countPulses(3, c);
    chk("R7 not suspended", c, 0);

    // R7: suspend release in the same cycle as a magic pulse
    suspendIn = 1'b1; tick();
    suspendIn = 1'b0; magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    countPulses(3, c);
    chk("R7 release meets magic pulse", c, 0);

    // R8: support flag clear blocks every source
    eeFlags = 16'hFFFB;
    rearm();
    magicPulse = 1'b1; tick(); magicPulse = 1'b0;
    linkUp = 1'b1;
    countPulses(4, c);
    chk("R8 support flag clear", c, 0);
    linkUp = 1'b0;
    eeFlags = 16'h0004;
    tick();

    // R10: write clearing enables in the same cycle as a link rise
    setReg(8'h03);
    rearm();
    linkUp = 1'b1;
    regWrEn = 1'b1;
    regWrData = 8'h00;
    tick();
    regWrEn = 1'b0;
    chk("R10 old enables govern event cycle", wakeReq, 1);
    chk("R10 write still lands", regRdData, 8'hA0);
    linkUp = 1'b0;
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule